// File: doc/BRIEF.md
# Global Busy and Live Trigger Latch

This block sits between the trigger sources and a set of readout partners, each either a crate controller or an external acquisition system. A raw trigger that arrives while every enabled partner is idle sets a live-trigger latch. The state of that latch drives the live trigger output, so the same signal also acts as the global busy of the whole acquisition. Each partner's busy and end-of-event lines feed back into the block, and the number of partners is a parameter.

When the live trigger is set, every enabled partner gets its own local latch. A partner clears its latch by pulsing its end-of-event line. The live latch is released only when three things are true: the OR of the enabled partner busies has fallen since the trigger, that OR is now low, and every local latch is cleared. This makes the global busy last as long as the slowest readout. A busy partner vetoes new raw triggers, which covers partners doing their own non-event readouts. An enable mask removes unused partners from both the veto and the release condition.

Raw triggers that do not set the latch are counted in a saturating counter. All inputs are asynchronous and pass through a synchronizer before any edge is detected.

Top module: `trig_busy_ctrl`

## Requirements
- R1: After reset, the live trigger is low, all local latches are low and the rejected-trigger count is zero.
- R2: A rising edge of the synchronized raw trigger sets the live trigger when the latch is clear and no enabled partner busy is high. The live trigger stays high as the global busy.
- R3: The cycle the live latch is set, the local latch of every enabled partner is set.
- R4: A rising edge on a partner's end-of-event input clears only that partner's local latch.
- R5: The live trigger clears once three conditions hold: the OR of enabled busies has fallen since the trigger, that OR is low, and all local latches are clear. It does not clear while any enabled busy remains high. A local latch is never high while the live trigger is low.
- R6: If the busy OR falls while a local latch is still set, the live trigger stays high until the last local latch is cleared.
- R7: A raw trigger edge while any enabled partner busy is high does not set the live trigger.
- R8: A raw trigger edge that does not set the live latch adds one to the rejected count. This applies whether the latch is already set or a busy vetoes the edge. The count does not change otherwise.
- R9: The rejected count saturates at its all-ones value.
- R10: A partner whose enable bit is 0 never vetoes, never gets a local latch, and is not needed for release.
- R11: Triggering is on edges. A raw trigger held high yields only one live trigger.
- R12: With no partner enabled, a live trigger releases by itself two cycles after it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_trig_i | input | 1 | Raw trigger, asynchronous |
| part_busy_i | input | N_PART | Busy line of each partner, asynchronous |
| part_eoe_i | input | N_PART | End-of-event line of each partner, asynchronous |
| part_en_i | input | N_PART | Partner enable mask, quasi-static |
| live_trig_o | output | 1 | Live trigger and global busy |
| local_busy_o | output | N_PART | Local latch of each partner |
| rej_count_o | output | REJ_W | Saturating count of rejected raw triggers |

## Verification
The assertions assume that the enable mask changes only while the live trigger is low. They also assume that each partner raises its busy after the live trigger and drops it only after its own end-of-event. The stimulus changes the mask only between scenarios, once the latch has been released. It drives every partner handshake in that order, except in the scenario where busy deliberately falls before the end-of-event pulses. All inputs are driven on the falling clock edge and held for at least one full cycle, so no pulse is lost in the synchronizer.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;

    typedef struct packed {
        logic live;
        logic fall_seen;
        logic busy_or_prev;
        logic trig_prev;
    } core_state_t;

    typedef struct packed {
        logic lat;
        logic eoe_prev;
    } partner_state_t;

endpackage

// File: rtl/tb_sync_bank.sv
module tb_sync_bank #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/partner_busy_latch.sv
module partner_busy_latch
    import trig_busy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic set_i,
    input  logic eoe_s_i,
    output logic lat_o
);
    partner_state_t st_d, st_q;
    logic           eoe_edge;

    always_comb begin
        st_d         = st_q;
        eoe_edge     = eoe_s_i & ~st_q.eoe_prev;
        st_d.eoe_prev = eoe_s_i;
        st_d.lat     = en_i & (set_i | (st_q.lat & ~eoe_edge));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_o = st_q.lat;

    // R10
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !lat_o);

    // R3
    rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_o) |-> $past(set_i));
endmodule

// File: rtl/live_latch_core.sv
module live_latch_core
    import trig_busy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_s_i,
    input  logic busy_or_i,
    input  logic local_or_i,
    input  logic none_en_i,
    output logic live_o,
    output logic set_o,
    output logic reject_o
);
    core_state_t st_d, st_q;
    logic        trig_edge;
    logic        busy_fall;

    always_comb begin
        st_d             = st_q;
        trig_edge        = trig_s_i & ~st_q.trig_prev;
        busy_fall        = st_q.busy_or_prev & ~busy_or_i;
        set_o            = trig_edge & ~st_q.live & ~busy_or_i;
        reject_o         = trig_edge & ~set_o;
        st_d.trig_prev    = trig_s_i;
        st_d.busy_or_prev = busy_or_i;
        if (set_o) begin
            st_d.live      = 1'b1;
            st_d.fall_seen = 1'b0;
        end else if (st_q.live) begin
            if (busy_fall || none_en_i) st_d.fall_seen = 1'b1;
            if (st_q.fall_seen && !local_or_i && !busy_or_i) begin
                st_d.live      = 1'b0;
                st_d.fall_seen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_o = st_q.live;

    // R7
    no_set_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live_o) |-> $past(!busy_or_i));

    // R6
    release_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(live_o) |-> $past(!local_or_i && !busy_or_i));
endmodule

// File: rtl/reject_counter.sv
module reject_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R9
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '1));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/trig_busy_ctrl.sv
module trig_busy_ctrl #(
    parameter int N_PART      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int REJ_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_trig_i,
    input  logic [N_PART-1:0] part_busy_i,
    input  logic [N_PART-1:0] part_eoe_i,
    input  logic [N_PART-1:0] part_en_i,
    output logic              live_trig_o,
    output logic [N_PART-1:0] local_busy_o,
    output logic [REJ_W-1:0]  rej_count_o
);
    logic              trig_s;
    logic [N_PART-1:0] busy_s;
    logic [N_PART-1:0] eoe_s;
    logic              busy_or;
    logic              local_or;
    logic              none_en;
    logic              live_set;
    logic              reject;

    tb_sync_bank #(.W(1), .STAGES(SYNC_STAGES)) u_sync_trig (
        .clk(clk), .rst_n(rst_n), .d_i(raw_trig_i), .q_o(trig_s)
    );
    tb_sync_bank #(.W(N_PART), .STAGES(SYNC_STAGES)) u_sync_busy (
        .clk(clk), .rst_n(rst_n), .d_i(part_busy_i), .q_o(busy_s)
    );
    tb_sync_bank #(.W(N_PART), .STAGES(SYNC_STAGES)) u_sync_eoe (
        .clk(clk), .rst_n(rst_n), .d_i(part_eoe_i), .q_o(eoe_s)
    );

    assign busy_or  = |(busy_s & part_en_i);
    assign local_or = |local_busy_o;
    assign none_en  = ~|part_en_i;

    live_latch_core u_core (
        .clk(clk), .rst_n(rst_n),
        .trig_s_i(trig_s), .busy_or_i(busy_or), .local_or_i(local_or),
        .none_en_i(none_en),
        .live_o(live_trig_o), .set_o(live_set), .reject_o(reject)
    );

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        partner_busy_latch u_lat (
            .clk(clk), .rst_n(rst_n),
            .en_i(part_en_i[p]), .set_i(live_set), .eoe_s_i(eoe_s[p]),
            .lat_o(local_busy_o[p])
        );
    end

    reject_counter #(.W(REJ_W)) u_rej (
        .clk(clk), .rst_n(rst_n), .inc_i(reject), .cnt_o(rej_count_o)
    );

    // R5
    local_within_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|local_busy_o) |-> live_trig_o);
endmodule

// File: tb/trig_busy_ctrl_bench.sv
`timescale 1ns/1ps
module trig_busy_ctrl_bench;
    localparam int N = 3;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          raw = 1'b0;
    logic [N-1:0]  busy = '0;
    logic [N-1:0]  eoe = '0;
    logic [N-1:0]  en = '1;
    logic          live;
    logic [N-1:0]  loc;
    logic [RW-1:0] cnt;

    int total = 0;
    int fails = 0;
    int rises = 0;
    logic live_prev = 1'b0;

    always #2.5 clk = ~clk;

    trig_busy_ctrl #(.N_PART(N), .SYNC_STAGES(2), .REJ_W(RW)) u_trig_busy_ctrl (
        .clk(clk), .rst_n(rst_n), .raw_trig_i(raw),
        .part_busy_i(busy), .part_eoe_i(eoe), .part_en_i(en),
        .live_trig_o(live), .local_busy_o(loc), .rej_count_o(cnt)
    );

    always @(posedge clk) begin
        if (live && !live_prev) rises++;
        live_prev <= live;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_raw();
        @(negedge clk) raw = 1'b1;
        @(negedge clk) raw = 1'b0;
        wait_cyc(2);
    endtask

    task automatic pulse_eoe(input int p);
        @(negedge clk) eoe[p] = 1'b1;
        @(negedge clk) eoe[p] = 1'b0;
        wait_cyc(5);
    endtask

    task automatic t_reset();
        check(live == 1'b0, "R1 live", live, 0);
        check(loc == '0, "R1 local", loc, 0);
        check(cnt == '0, "R1 count", cnt, 0);
    endtask

    task automatic t_basic();
        int r0 = rises;
        en = 3'b111;
        pulse_raw();
        wait_cyc(4);
        check(live == 1'b1, "R2 live set", live, 1);
        check(rises == r0 + 1, "R2 one rise", rises - r0, 1);
        check(loc == 3'b111, "R3 locals set", loc, 7);
        busy = 3'b111;
        wait_cyc(4);
        pulse_eoe(0);
        check(loc == 3'b110, "R4 only partner 0 cleared", loc, 6);
        pulse_eoe(1);
        pulse_eoe(2);
        check(loc == 3'b000, "R4 all cleared", loc, 0);
        check(live == 1'b1, "R5 held by busy", live, 1);
        @(negedge clk) busy = 3'b011;
        wait_cyc(5);
        check(live == 1'b1, "R5 held by slowest busy", live, 1);
        @(negedge clk) busy = 3'b000;
        wait_cyc(6);
        check(live == 1'b0, "R5 released", live, 0);
    endtask

    task automatic t_early();
        pulse_raw();
        wait_cyc(4);
        busy = 3'b111;
        wait_cyc(4);
        @(negedge clk) busy = 3'b000;
        wait_cyc(6);
        check(live == 1'b1, "R6 held by locals", live, 1);
        pulse_eoe(0);
        pulse_eoe(1);
        check(live == 1'b1, "R6 held by last local", live, 1);
        pulse_eoe(2);
        wait_cyc(2);
        check(live == 1'b0, "R6 released after last eoe", live, 0);
    endtask

    task automatic t_veto();
        int r0 = rises;
        int c0 = cnt;
        @(negedge clk) busy = 3'b010;
        wait_cyc(4);
        pulse_raw();
        wait_cyc(4);
        check(live == 1'b0, "R7 vetoed", live, 0);
        check(rises == r0, "R7 no rise", rises - r0, 0);
        check(cnt == c0 + 1, "R8 veto counted", cnt, c0 + 1);
        @(negedge clk) busy = 3'b000;
        wait_cyc(6);
        check(cnt == c0 + 1, "R8 count stable", cnt, c0 + 1);
    endtask

    task automatic t_ignore();
        int r0 = rises;
        int c0 = cnt;
        pulse_raw();
        wait_cyc(4);
        pulse_raw();
        wait_cyc(4);
        check(live == 1'b1, "R8 still live", live, 1);
        check(rises == r0 + 1, "R8 no second rise", rises - r0, 1);
        check(cnt == c0 + 1, "R8 ignored counted", cnt, c0 + 1);
        busy = 3'b111;
        wait_cyc(4);
        pulse_eoe(0); pulse_eoe(1); pulse_eoe(2);
        @(negedge clk) busy = 3'b000;
        wait_cyc(6);
        check(live == 1'b0, "R8 cycle closed", live, 0);
    endtask

    task automatic t_level();
        int r0 = rises;
        @(negedge clk) raw = 1'b1;
        wait_cyc(6);
        check(live == 1'b1, "R11 set by level", live, 1);
        busy = 3'b111;
        wait_cyc(4);
        pulse_eoe(0); pulse_eoe(1); pulse_eoe(2);
        @(negedge clk) busy = 3'b000;
        wait_cyc(10);
        check(live == 1'b0, "R11 no retrigger on held level", live, 0);
        check(rises == r0 + 1, "R11 single rise", rises - r0, 1);
        @(negedge clk) raw = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_mask();
        @(negedge clk) begin en = 3'b101; busy = 3'b010; end
        wait_cyc(4);
        pulse_raw();
        wait_cyc(4);
        check(live == 1'b1, "R10 masked busy no veto", live, 1);
        check(loc == 3'b101, "R10 no local for masked", loc, 5);
        busy = 3'b111;
        wait_cyc(4);
        pulse_eoe(0); pulse_eoe(2);
        @(negedge clk) busy = 3'b010;
        wait_cyc(6);
        check(live == 1'b0, "R10 masked not needed", live, 0);
        @(negedge clk) begin busy = 3'b000; en = 3'b111; end
        wait_cyc(4);
    endtask

    task automatic t_none();
        int r0 = rises;
        @(negedge clk) en = 3'b000;
        wait_cyc(2);
        pulse_raw();
        wait_cyc(6);
        check(rises == r0 + 1, "R12 fired", rises - r0, 1);
        check(live == 1'b0, "R12 self release", live, 0);
        check(loc == 3'b000, "R12 no locals", loc, 0);
        @(negedge clk) en = 3'b111;
        wait_cyc(2);
    endtask

    task automatic t_sat();
        @(negedge clk) busy = 3'b001;
        wait_cyc(4);
        for (int i = 0; i < 10; i++) pulse_raw();
        wait_cyc(4);
        check(cnt == 3'b111, "R9 saturated", cnt, 7);
        @(negedge clk) busy = 3'b000;
        wait_cyc(4);
    endtask

    initial begin
        #2_000_000;
        fails++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        wait_cyc(3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(3);
        t_basic();
        t_early();
        t_veto();
        t_ignore();
        t_level();
        t_mask();
        t_none();
        t_sat();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule